// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit buses, called A and B, and moves data from one to the other in either direction. For each direction it holds one storage register. The register for the A-to-B path samples the A bus when its capture strobe rises. The register for the B-to-A path samples the B bus when its own strobe rises. A multiplexer sits in front of each driven port. It forwards either the live value on the opposite bus or the copy held in that direction's register.

Each bus appears as three separate signals: an input vector, an output vector and an output-enable vector. The surrounding logic joins them into a real tri-state pad. An active-low enable isolates both buses. When the enable is low, a direction input chooses which bus is driven. The registers keep capturing in every mode, including isolation.

Both capture strobes are ordinary inputs. The block samples them on its system clock and reacts to a low-to-high change seen between two consecutive clock edges.

Top module: `bus_xcvr_reg`

## Requirements
- R1: A synchronous active-high reset clears both storage registers to 0x00. After reset, stored mode shows 0x00 on whichever port is driven.
- R2: At a clock edge where `stb_ab` is high and was low at the previous edge, the A-to-B register loads `a_in`. From the next cycle on, that value appears on `b_out` whenever B is driven in stored mode.
- R3: At a clock edge where `stb_ba` is high and was low at the previous edge, the B-to-A register loads `b_in`. From the next cycle on, that value appears on `a_out` whenever A is driven in stored mode.
- R4: Capture in both registers is independent of `oe_n` and `dir`. It works in isolation and on the port that is currently receiving.
- R5: With `oe_n` = 1 (isolation), `a_oe` and `b_oe` are both 0x00.
- R6: With `oe_n` = 0 and `dir` = 1, `b_oe` = 0xFF and `a_oe` = 0x00. With `oe_n` = 0 and `dir` = 0, `a_oe` = 0xFF and `b_oe` = 0x00. No enable vector ever takes a value other than all zeros or all ones.
- R7: While B is driven and `sel_ab` = 0, `b_out` equals `a_in` in the same cycle, through logic with no register on the path.
- R8: While A is driven and `sel_ba` = 0, `a_out` equals `b_in` in the same cycle, through logic with no register on the path.
- R9: While a port is driven with its select = 1, it shows the stored register of the opposite direction.
- R10: A strobe that stays high captures only once. A strobe that is already high when reset ends captures nothing until it has gone low and risen again.
- R11: The select of the direction that is not being driven, and the strobe of the receiving port, have no effect on the driven output.
- R12: An output whose enable vector is 0x00 carries 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_n | input | 1 | Active-low output enable; 1 isolates both buses |
| dir | input | 1 | 1 drives B from A, 0 drives A from B |
| sel_ab | input | 1 | B-side source: 0 live A bus, 1 stored A-to-B register |
| sel_ba | input | 1 | A-side source: 0 live B bus, 1 stored B-to-A register |
| stb_ab | input | 1 | Capture strobe of the A-to-B register (rising change) |
| stb_ba | input | 1 | Capture strobe of the B-to-A register (rising change) |
| a_in | input | 8 | Value seen on the A bus |
| b_in | input | 8 | Value seen on the B bus |
| a_out | output | 8 | Value driven onto the A bus |
| a_oe | output | 8 | Per-bit drive enable for the A bus |
| b_out | output | 8 | Value driven onto the B bus |
| b_oe | output | 8 | Per-bit drive enable for the B bus |

## Verification
The hardest situation to reach is a register that was loaded while its contents could not be seen. This happens when capture occurs in isolation, or on the bus that is receiving. The contents can only be observed later, after the controls are switched so that stored mode drives the other port.

The bench pulses both strobes while the block is isolated, and while the opposite direction is being driven transparently. It then re-steers `dir` with the select set to stored and reads the held values.

A second case that needs care is a strobe held high across the release of reset. The bench raises the strobe during reset, releases reset and lets several cycles pass. It then confirms through stored mode that the register still holds zero.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int XCVR_WIDTH = 8;
    localparam int XCVR_DIRS  = 2;
    localparam int PATH_AB    = 0;
    localparam int PATH_BA    = 1;

    typedef enum logic [1:0] {
        XM_ISOLATE = 2'd0,
        XM_DRIVE_B = 2'd1,
        XM_DRIVE_A = 2'd2
    } xmode_e;

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_e;

    typedef struct packed {
        logic drive_b;
        logic drive_a;
        src_e src_ab;
        src_e src_ba;
    } path_ctrl_t;

    function automatic xmode_e decode_mode(input logic oe_n, input logic dir);
        xmode_e m;
        if (oe_n)     m = XM_ISOLATE;
        else if (dir) m = XM_DRIVE_B;
        else          m = XM_DRIVE_A;
        return m;
    endfunction

    function automatic src_e pick_src(input logic sel);
        return sel ? SRC_STORED : SRC_LIVE;
    endfunction

endpackage

// File: rtl/xcvr_ctrl_dec.sv
module xcvr_ctrl_dec
    import xcvr_pkg::*;
(
    input  logic       oe_n,
    input  logic       dir,
    input  logic       sel_ab,
    input  logic       sel_ba,
    output path_ctrl_t ctrl
);
    xmode_e mode;

    always_comb begin
        mode         = decode_mode(oe_n, dir);
        ctrl.drive_b = (mode == XM_DRIVE_B);
        ctrl.drive_a = (mode == XM_DRIVE_A);
        ctrl.src_ab  = pick_src(sel_ab);
        ctrl.src_ba  = pick_src(sel_ba);
    end
endmodule

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stb,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic stb_prev;
    logic load;

    // Previous strobe sample is kept even in reset, so a strobe held high
    // across reset release does not look like a fresh rising change.
    always_ff @(posedge clk) begin
        stb_prev <= stb;
    end

    assign load = stb & ~stb_prev;

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/xcvr_port_drv.sv
module xcvr_port_drv
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         drive,
    input  src_e         src,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] out,
    output logic [W-1:0] oe
);
    logic [W-1:0] chosen;

    always_comb begin
        chosen = (src == SRC_STORED) ? stored : live;
        out    = drive ? chosen : '0;
        oe     = {W{drive}};
    end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
    import xcvr_pkg::*;
#(
    parameter int W = XCVR_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         oe_n,
    input  logic         dir,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic         stb_ab,
    input  logic         stb_ba,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);
    path_ctrl_t   ctrl;
    logic [W-1:0] src_bus  [XCVR_DIRS];
    logic [W-1:0] held     [XCVR_DIRS];
    logic [W-1:0] drv_out  [XCVR_DIRS];
    logic [W-1:0] drv_oe   [XCVR_DIRS];
    logic         stb      [XCVR_DIRS];
    logic         drive    [XCVR_DIRS];
    src_e         src      [XCVR_DIRS];

    xcvr_ctrl_dec u_dec (
        .oe_n   (oe_n),
        .dir    (dir),
        .sel_ab (sel_ab),
        .sel_ba (sel_ba),
        .ctrl   (ctrl)
    );

    // Path 0 carries A to B, path 1 carries B to A.
    assign src_bus[PATH_AB] = a_in;
    assign src_bus[PATH_BA] = b_in;
    assign stb[PATH_AB]     = stb_ab;
    assign stb[PATH_BA]     = stb_ba;
    assign drive[PATH_AB]   = ctrl.drive_b;
    assign drive[PATH_BA]   = ctrl.drive_a;
    assign src[PATH_AB]     = ctrl.src_ab;
    assign src[PATH_BA]     = ctrl.src_ba;

    for (genvar g = 0; g < XCVR_DIRS; g++) begin : g_path
        xcvr_cap_reg #(.W(W)) u_reg (
            .clk (clk),
            .rst (rst),
            .stb (stb[g]),
            .d   (src_bus[g]),
            .q   (held[g])
        );

        xcvr_port_drv #(.W(W)) u_drv (
            .drive  (drive[g]),
            .src    (src[g]),
            .live   (src_bus[g]),
            .stored (held[g]),
            .out    (drv_out[g]),
            .oe     (drv_oe[g])
        );
    end

    assign b_out = drv_out[PATH_AB];
    assign b_oe  = drv_oe[PATH_AB];
    assign a_out = drv_out[PATH_BA];
    assign a_oe  = drv_oe[PATH_BA];
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         oe_n,
    input logic         dir,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic         stb_ab,
    input logic         stb_ba,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] a_out,
    input logic [W-1:0] a_oe,
    input logic [W-1:0] b_out,
    input logic [W-1:0] b_oe
);
    AST_ISOLATE: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (a_oe == '0 && b_oe == '0)); // R5

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
        !(a_oe != '0 && b_oe != '0)); // R6

    AST_OE_UNIFORM: assert property (@(posedge clk) disable iff (rst)
        (a_oe == '0 || a_oe == '1) && (b_oe == '0 || b_oe == '1)); // R6

    AST_PASS_AB: assert property (@(posedge clk) disable iff (rst)
        (!oe_n && dir && !sel_ab) |-> (b_out == a_in)); // R7

    AST_PASS_BA: assert property (@(posedge clk) disable iff (rst)
        (!oe_n && !dir && !sel_ba) |-> (a_out == b_in)); // R8

    AST_CAPTURE_AB: assert property (@(posedge clk) disable iff (rst)
        $rose(stb_ab) |=> ((!oe_n && dir && sel_ab) ? (b_out == $past(a_in)) : 1'b1)); // R2

    AST_CAPTURE_BA: assert property (@(posedge clk) disable iff (rst)
        $rose(stb_ba) |=> ((!oe_n && !dir && sel_ba) ? (a_out == $past(b_in)) : 1'b1)); // R3

    AST_QUIET_OUT: assert property (@(posedge clk) disable iff (rst)
        ((a_oe == '0) |-> (a_out == '0)) and ((b_oe == '0) |-> (b_out == '0))); // R12
endmodule

bind bus_xcvr_reg xcvr_checker #(.W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .oe_n   (oe_n),
    .dir    (dir),
    .sel_ab (sel_ab),
    .sel_ba (sel_ba),
    .stb_ab (stb_ab),
    .stb_ba (stb_ba),
    .a_in   (a_in),
    .b_in   (b_in),
    .a_out  (a_out),
    .a_oe   (a_oe),
    .b_out  (b_out),
    .b_oe   (b_oe)
);

// File: tb/bus_xcvr_reg_bench.sv
module bus_xcvr_reg_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       oe_n, dir, sel_ab, sel_ba, stb_ab, stb_ba;
    logic [7:0] a_in, b_in;
    logic [7:0] a_out, a_oe, b_out, b_oe;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    bus_xcvr_reg u_bus_xcvr_reg (
        .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .stb_ab(stb_ab), .stb_ba(stb_ba),
        .a_in(a_in), .b_in(b_in),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One-cycle strobe pulse: raised at a negedge, lowered at the next.
    task automatic pulse_ab(input logic [7:0] v);
        a_in = v; stb_ab = 1'b1; tick(1); stb_ab = 1'b0; tick(1);
    endtask

    task automatic pulse_ba(input logic [7:0] v);
        b_in = v; stb_ba = 1'b1; tick(1); stb_ba = 1'b0; tick(1);
    endtask

    task automatic t_reset;
        rst = 1'b1; tick(3); rst = 1'b0; tick(1);
        oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; #1;
        chk("R1 stored A-to-B after reset", b_out, 8'h00);
        dir = 1'b0; sel_ba = 1'b1; #1;
        chk("R1 stored B-to-A after reset", a_out, 8'h00);
    endtask

    task automatic t_isolate;
        oe_n = 1'b1; a_in = 8'hA5; b_in = 8'h5A; sel_ab = 1'b0; sel_ba = 1'b0;
        for (int d = 0; d < 2; d++) begin
            dir = d[0]; #1;
            chk("R5 a_oe isolated", a_oe, 8'h00);
            chk("R5 b_oe isolated", b_oe, 8'h00);
            chk("R12 a_out quiet", a_out, 8'h00);
            chk("R12 b_out quiet", b_out, 8'h00);
        end
    endtask

    task automatic t_direction;
        oe_n = 1'b0; dir = 1'b1; b_in = 8'h3C; sel_ba = 1'b0; #1;
        chk("R6 b_oe driving", b_oe, 8'hFF);
        chk("R6 a_oe receiving", a_oe, 8'h00);
        chk("R12 a_out quiet while receiving", a_out, 8'h00);
        dir = 1'b0; #1;
        chk("R6 a_oe driving", a_oe, 8'hFF);
        chk("R6 b_oe receiving", b_oe, 8'h00);
    endtask

    task automatic t_transparent;
        logic [7:0] pat [4] = '{8'h00, 8'hFF, 8'h81, 8'h6E};
        oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b0;
        foreach (pat[i]) begin a_in = pat[i]; #1; chk("R7 live A to B", b_out, pat[i]); end
        dir = 1'b0; sel_ba = 1'b0;
        foreach (pat[i]) begin b_in = ~pat[i]; #1; chk("R8 live B to A", a_out, ~pat[i]); end
        tick(1);
    endtask

    task automatic t_capture_ab;
        oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1;
        pulse_ab(8'h5A);
        a_in = 8'h11; #1;
        chk("R2 R9 stored A-to-B", b_out, 8'h5A);
        a_in = 8'h33; stb_ab = 1'b1; tick(1);
        chk("R2 new capture shows on B", b_out, 8'h33);
        a_in = 8'h77; tick(2);
        chk("R10 held strobe no recapture", b_out, 8'h33);
        stb_ab = 1'b0; tick(1);
        pulse_ab(8'h77);
        chk("R10 recapture after low", b_out, 8'h77);
    endtask

    task automatic t_capture_ba;
        oe_n = 1'b0; dir = 1'b0; sel_ba = 1'b1;
        pulse_ba(8'hC9);
        b_in = 8'h00; #1;
        chk("R3 R9 stored B-to-A", a_out, 8'hC9);
    endtask

    task automatic t_iso_capture;
        oe_n = 1'b1;
        pulse_ab(8'hC3);
        pulse_ba(8'h96);
        oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; #1;
        chk("R4 A-to-B captured in isolation", b_out, 8'hC3);
        dir = 1'b0; sel_ba = 1'b1; #1;
        chk("R4 B-to-A captured in isolation", a_out, 8'h96);
    endtask

    task automatic t_unused;
        oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b0; a_in = 8'h11; sel_ba = 1'b0; #1;
        chk("R11 baseline", b_out, 8'h11);
        sel_ba = 1'b1; #1;
        chk("R11 sel_ba ignored", b_out, 8'h11);
        b_in = 8'h77; stb_ba = 1'b1; tick(1);
        chk("R11 stb_ba ignored", b_out, 8'h11);
        stb_ba = 1'b0; tick(1);
        chk("R11 after strobe", b_out, 8'h11);
        dir = 1'b0; #1;
        chk("R4 captured on receiving port", a_out, 8'h77);
    endtask

    task automatic t_reset_held;
        stb_ab = 1'b1; a_in = 8'hE7; rst = 1'b1; tick(2);
        rst = 1'b0; tick(3);
        oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; #1;
        chk("R10 R1 strobe high through reset", b_out, 8'h00);
        stb_ab = 1'b0; tick(1);
    endtask

    initial begin
        rst = 1'b1; oe_n = 1'b1; dir = 1'b0; sel_ab = 1'b0; sel_ba = 1'b0;
        stb_ab = 1'b0; stb_ba = 1'b0; a_in = '0; b_in = '0;
        tick(1);
        t_reset();
        t_isolate();
        t_direction();
        t_transparent();
        t_capture_ab();
        t_capture_ba();
        t_iso_capture();
        t_unused();
        t_reset_held();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                total++; bad++;
                $display("FAIL watchdog expired");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end
endmodule